// File: doc/BRIEF.md
# Scanline Event Scheduler with Timer Interrupts

This block keeps the video-derived time base for a small 8-bit processor system. During a run of a requested number of display lines it accumulates the cycles the processor reports each clock. It also advances a line counter that wraps once per frame. At every line boundary it adds a fixed penalty for the cycles that display fetch takes from the processor.

Three one-shot countdown timers can be armed at any time. When the cycle count reaches a timer's expiry, that timer's bit in an active-low status byte drops to 0. Software sets such a bit back to 1 by writing a 1 to it.

The scheduler evaluates interrupts at three kinds of moment: a line boundary, a timer expiry, or a processor report that the interrupt-disable flag may just have been cleared. At such a moment it decides whether the processor must enter its maskable interrupt, and in that case adds the cost of the interrupt entry to the cycle count. When the run ends, the cycle count and every pending timer expiry are rebased by the run length, so the counters stay small.

Top module: `scan_sched`

## Requirements
- R1: A line lasts 114 cycles. The clock in which the cycle count is at or past the next line boundary adds 9 stolen cycles to the count. The boundary then moves on by 114.
- R2: Each line boundary advances `line_no`. The value 311 is followed by 0, and `line_no` never exceeds 311.
- R3: `run_start` with a nonzero `run_lines` value N starts a run while the block is idle. The run ends in the clock that reaches the Nth boundary. In that clock the cycle count becomes (count + 9 − 114·N), `adv` is ignored, and `run_done` is high for exactly one clock afterwards.
- R4: A pulse on `tmr_load[i]` arms timer i with expiry = current cycle count + `tmr_value`. In the running clock where the count (including that clock's stolen cycles) is at or past the expiry, status bit i becomes 0 and timer i disarms. Bit i of `irq_status` belongs to timer i (masks 1, 2, 4).
- R5: A timer still armed when a run ends keeps its status bit at 1. Its expiry is lowered by 114·N, so it fires that much earlier in cycle-count terms during the next run.
- R6: A 1 in `irq_ack[i]` sets status bit i to 1 in the next clock.
- R7: When `tmr_load[i]` arrives in the very clock in which timer i would expire, the load takes effect, the status bit stays at 1, and the new expiry counts from that clock's cycle count.
- R8: `irq_take` is asserted combinationally in a running, non-final clock that meets three conditions: a line boundary, a timer expiry or `flag_clr` occurs; `irq_mask` is 0; and the status byte after this clock's updates is not 0xFF. In that clock `irq_cost` reads 7, and 7 extra cycles are added to the count. With no such event, no interrupt is taken.
- R9: Reset sets `irq_status` to 0xFF and sets `line_no`, the cycle count and `run_done` to 0. It also disarms all timers. Bits 7..3 of `irq_status` always read 1.
- R10: While idle, `adv` has no effect on the cycle count and no timer expires.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| run_start | input | 1 | Start a run (sampled while idle) |
| run_lines | input | 10 | Number of lines in the run |
| adv | input | 4 | Processor cycles consumed this clock |
| irq_mask | input | 1 | Processor interrupt-disable flag |
| flag_clr | input | 1 | The instruction just executed may have cleared the disable flag |
| tmr_load | input | 3 | Per-timer arm strobe |
| tmr_value | input | 20 | Delay in cycles for the timer being armed |
| irq_ack | input | 3 | Per-timer status acknowledge (1 sets the bit) |
| line_no | output | 9 | Current line within the frame |
| irq_status | output | 8 | Active-low interrupt status |
| irq_take | output | 1 | Processor must enter the interrupt now |
| irq_cost | output | 4 | Cycles charged for the interrupt entry (0 when none) |
| run_done | output | 1 | One-clock pulse after a run ends |
| cyc_now | output | 20 | Cycle count within the run |

## Verification
The assertions rely on the processor setting `irq_mask` in the clock after `irq_take`. They also rely on reset being held for at least two clocks, so that no past value predates reset. The bench sets the mask right after every observed take and holds reset for several clocks. The checks also assume that `adv` and the timer delays keep the cycle count far below its 20-bit limit. The bench uses advances of at most 13 cycles and delays of at most 200, so the counts stay in the low hundreds.

// File: rtl/scan_sched.sv
module scan_sched #(
  parameter int CW       = 20,
  parameter int NW       = 10,
  parameter int AW       = 4,
  parameter int NT       = 3,
  parameter int LINE_CYC = 114,
  parameter int STEAL    = 9,
  parameter int LINES    = 312,
  parameter int IRQ_COST = 7
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      run_start,
  input  logic [NW-1:0]             run_lines,
  input  logic [AW-1:0]             adv,
  input  logic                      irq_mask,
  input  logic                      flag_clr,
  input  logic [NT-1:0]             tmr_load,
  input  logic [CW-1:0]             tmr_value,
  input  logic [NT-1:0]             irq_ack,
  output logic [$clog2(LINES)-1:0]  line_no,
  output logic [7:0]                irq_status,
  output logic                      irq_take,
  output logic [3:0]                irq_cost,
  output logic                      run_done,
  output logic [CW-1:0]             cyc_now
);
  localparam int LW = $clog2(LINES);
  localparam logic [NT-1:0] ALL1 = '1;

  logic          running;
  logic [NW-1:0] left;
  logic [CW-1:0] nl, limit, c1, base;
  logic [CW-1:0] texp [NT];
  logic [NT-1:0] act, st, hit, st_n;
  logic          line_hit, last;

  assign line_hit = running && (cyc_now >= nl);
  assign last     = line_hit && (left == NW'(1));
  assign c1       = cyc_now + (line_hit ? CW'(STEAL) : '0);
  assign base     = last ? c1 - limit : cyc_now;

  always_comb
    for (int i = 0; i < NT; i++)
      hit[i] = running && !last && act[i] && !tmr_load[i] && (c1 >= texp[i]);

  assign st_n       = (st | irq_ack) & ~hit;
  assign irq_take   = running && !last && !irq_mask &&
                      (line_hit || (|hit) || flag_clr) && (st_n != ALL1);
  assign irq_cost   = irq_take ? 4'(IRQ_COST) : 4'd0;
  assign irq_status = {{(8-NT){1'b1}}, st};

  always_ff @(posedge clk) begin
    if (rst) begin
      running  <= 1'b0;
      left     <= '0;
      nl       <= '0;
      limit    <= '0;
      cyc_now  <= '0;
      line_no  <= '0;
      st       <= '1;
      act      <= '0;
      run_done <= 1'b0;
      for (int i = 0; i < NT; i++) texp[i] <= '0;
    end else begin
      run_done <= 1'b0;
      st       <= st_n;
      for (int i = 0; i < NT; i++) begin
        if (tmr_load[i]) begin
          texp[i] <= base + tmr_value;
          act[i]  <= 1'b1;
        end else if (hit[i]) begin
          act[i]  <= 1'b0;
        end else if (last && act[i]) begin
          texp[i] <= (texp[i] > limit) ? texp[i] - limit : '0;
        end
      end
      if (!running) begin
        if (run_start && run_lines != '0) begin
          running <= 1'b1;
          left    <= run_lines;
          nl      <= CW'(LINE_CYC);
          limit   <= CW'(LINE_CYC) * CW'(run_lines);
        end
      end else begin
        if (line_hit)
          line_no <= (line_no == LW'(LINES-1)) ? '0 : line_no + 1'b1;
        if (last) begin
          running  <= 1'b0;
          run_done <= 1'b1;
          cyc_now  <= c1 - limit;
        end else begin
          cyc_now <= c1 + (irq_take ? CW'(IRQ_COST) : '0) + CW'(adv);
          if (line_hit) begin
            nl   <= nl + CW'(LINE_CYC);
            left <= left - 1'b1;
          end
        end
      end
    end
  end

  // R2
  line_range_chk: assert property (@(posedge clk) disable iff (rst)
    line_no <= LW'(LINES-1));
  // R3
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    run_done |=> !run_done);
  // R3
  done_idle_chk: assert property (@(posedge clk) disable iff (rst)
    run_done |-> !running);
  // R10
  idle_cyc_chk: assert property (@(posedge clk) disable iff (rst)
    !running |=> $stable(cyc_now));
  // R10
  idle_fall_chk: assert property (@(posedge clk) disable iff (rst)
    !running |=> (($past(st) & ~st) == '0));
  // R8
  take_gate_chk: assert property (@(posedge clk) disable iff (rst)
    irq_take |-> (!irq_mask && running));
endmodule

// File: tb/scan_sched_test.sv
`timescale 1ns/100ps
module scan_sched_test;
  logic        clk = 0, rst = 1, run_start = 0, irq_mask = 1, flag_clr = 0;
  logic [9:0]  run_lines = '0;
  logic [3:0]  adv = '0;
  logic [2:0]  tmr_load = '0, irq_ack = '0;
  logic [19:0] tmr_value = '0;
  logic [8:0]  line_no;
  logic [7:0]  irq_status;
  logic        irq_take, run_done;
  logic [3:0]  irq_cost;
  logic [19:0] cyc_now;

  int checks = 0, fails = 0, cnt = 0, takes = 0;
  int fall_c [3];
  bit finished = 0;

  localparam int NV = 7;
  localparam int VEC [NV][2] = '{'{1,10}, '{2,7}, '{3,5}, '{1,3}, '{4,13}, '{312,13}, '{2,1}};

  scan_sched uut (
    .clk(clk), .rst(rst), .run_start(run_start), .run_lines(run_lines),
    .adv(adv), .irq_mask(irq_mask), .flag_clr(flag_clr), .tmr_load(tmr_load),
    .tmr_value(tmr_value), .irq_ack(irq_ack), .line_no(line_no),
    .irq_status(irq_status), .irq_take(irq_take), .irq_cost(irq_cost),
    .run_done(run_done), .cyc_now(cyc_now));

  always #2.5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic predict(input int start, input int n, input int a,
                         output int endc, output int clocks);
    int c = start, nl = 114, left = n;
    bit stop = 0;
    clocks = 0;
    while (!stop) begin
      clocks++;
      if (c >= nl) begin
        c += 9;
        if (left == 1) begin
          c -= 114 * n;
          stop = 1;
        end else begin
          left--;
          nl += 114;
        end
      end
      if (!stop) c += a;
    end
    endc = c;
  endtask

  task automatic start_run(input int n, input int a);
    @(negedge clk); run_start = 1; run_lines = 10'(n); adv = 4'(a);
    @(negedge clk); run_start = 0; #1;
  endtask

  task automatic wait_done();
    for (int k = 0; k < 10000; k++) begin
      if (run_done) break;
      @(negedge clk); #1;
    end
    adv = 0;
  endtask

  task automatic do_run(input int n, input int a);
    logic [2:0] prev;
    start_run(n, a);
    prev = irq_status[2:0];
    cnt = 0; takes = 0;
    for (int i = 0; i < 3; i++) fall_c[i] = -1;
    while (cnt < 10000) begin
      @(negedge clk); #1;
      cnt++;
      for (int i = 0; i < 3; i++)
        if (prev[i] && !irq_status[i] && fall_c[i] < 0) fall_c[i] = int'(cyc_now);
      prev = irq_status[2:0];
      if (irq_take) takes++;
      if (run_done) break;
    end
    adv = 0;
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      fails++;
      $display("FAIL R3 watchdog actual=running expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int cyc_m = 0, line_m = 0, endc, clocks, c0, ta, fell;
    bit reloaded, justr;

    repeat (3) @(negedge clk); #1;
    // R9 reset state
    chk(irq_status == 8'hFF, "R9 status", irq_status, 255);
    chk(line_no == 0, "R9 line", line_no, 0);
    chk(cyc_now == 0, "R9 cycles", cyc_now, 0);
    chk(run_done == 0 && irq_take == 0, "R9 strobes", run_done, 0);
    rst = 0;

    for (int v = 0; v < NV; v++) begin
      predict(cyc_m, VEC[v][0], VEC[v][1], endc, clocks);
      do_run(VEC[v][0], VEC[v][1]);
      line_m = (line_m + VEC[v][0]) % 312;
      chk(cnt == clocks, "R3 run length", cnt, clocks);
      chk(int'(cyc_now) == endc, "R1 cycle count with steal", cyc_now, endc);
      chk(int'(line_no) == line_m, "R2 line number", line_no, line_m);
      chk(takes == 0, "R8 no take while masked", takes, 0);
      @(negedge clk); #1;
      chk(run_done == 0, "R3 done pulse width", run_done, 0);
      cyc_m = endc;
    end

    // R4 timer0 expiry; R5 timer1 carried over
    c0 = int'(cyc_now);
    @(negedge clk); tmr_load = 3'b011; tmr_value = 20'd40;
    @(negedge clk); tmr_load = 3'b010; tmr_value = 20'd200;
    @(negedge clk); tmr_load = 0;
    do_run(1, 1);
    chk(fall_c[0] == c0 + 41, "R4 timer0 fall cycle", fall_c[0], c0 + 41);
    chk(irq_status[1] == 1, "R5 pending timer bit", irq_status[1], 1);
    do_run(1, 1);
    chk(fall_c[1] == c0 + 87, "R5 rebased expiry", fall_c[1], c0 + 87);
    chk(irq_status == 8'hFC, "R4 status after expiries", irq_status, 8'hFC);

    // R6 acknowledge
    @(negedge clk); irq_ack = 3'b001;
    @(negedge clk); irq_ack = 0; #1;
    chk(irq_status == 8'hFD, "R6 ack bit0", irq_status, 8'hFD);

    // R7 load wins over expiry
    c0 = int'(cyc_now);
    @(negedge clk); tmr_load = 3'b100; tmr_value = 20'd5;
    @(negedge clk); tmr_load = 0;
    start_run(1, 1);
    reloaded = 0; justr = 0; fell = -1;
    for (int k = 0; k < 1000; k++) begin
      if (!reloaded && int'(cyc_now) == c0 + 5) begin
        tmr_load = 3'b100; tmr_value = 20'd20; reloaded = 1; justr = 1;
      end
      @(negedge clk); tmr_load = 0; #1;
      if (justr) begin
        chk(irq_status[2] == 1, "R7 bit kept on reload", irq_status[2], 1);
        justr = 0;
      end
      if (fell < 0 && !irq_status[2]) fell = int'(cyc_now);
      if (run_done) break;
    end
    chk(fell == c0 + 26, "R7 new expiry", fell, c0 + 26);

    // R8 take on timer expiry
    @(negedge clk); irq_ack = 3'b111;
    @(negedge clk); irq_ack = 0; #1;
    chk(irq_status == 8'hFF, "R6 ack all", irq_status, 255);
    c0 = int'(cyc_now);
    @(negedge clk); tmr_load = 3'b001; tmr_value = 20'd30; irq_mask = 0;
    @(negedge clk); tmr_load = 0;
    start_run(1, 1);
    ta = -1;
    for (int k = 0; k < 1000; k++) begin
      if (irq_take && ta < 0) begin
        ta = int'(cyc_now);
        chk(irq_cost == 7, "R8 entry cost", irq_cost, 7);
        @(negedge clk); irq_mask = 1; #1;
        chk(int'(cyc_now) == ta + 8, "R8 cost charged", cyc_now, ta + 8);
      end else begin
        @(negedge clk); #1;
      end
      if (run_done) break;
    end
    chk(ta == c0 + 30, "R8 take at expiry", ta, c0 + 30);

    // R8 flag-clear re-evaluation
    start_run(1, 1);
    @(negedge clk); flag_clr = 1; #1;
    chk(irq_take == 0, "R8 masked flag event", irq_take, 0);
    @(negedge clk); flag_clr = 0; irq_mask = 0; #1;
    chk(irq_take == 0, "R8 no event no take", irq_take, 0);
    @(negedge clk); flag_clr = 1; #1;
    chk(irq_take == 1, "R8 take on flag event", irq_take, 1);
    c0 = int'(cyc_now);
    @(negedge clk); flag_clr = 0; irq_mask = 1; #1;
    chk(int'(cyc_now) == c0 + 8, "R8 flag take cost", cyc_now, c0 + 8);
    wait_done();
    @(negedge clk); irq_ack = 3'b001;
    @(negedge clk); irq_ack = 0; #1;
    start_run(1, 1);
    @(negedge clk); irq_mask = 0; flag_clr = 1; #1;
    chk(irq_take == 0, "R8 status all ones", irq_take, 0);
    @(negedge clk); irq_mask = 1; flag_clr = 0; #1;
    wait_done();

    // R10 idle behaviour
    @(negedge clk); adv = 4'd15; #1;
    c0 = int'(cyc_now);
    repeat (4) @(negedge clk); #1;
    chk(int'(cyc_now) == c0, "R10 adv ignored idle", cyc_now, c0);
    adv = 0;
    @(negedge clk); tmr_load = 3'b010; tmr_value = 20'd0;
    @(negedge clk); tmr_load = 0;
    repeat (3) @(negedge clk); #1;
    chk(irq_status == 8'hFF, "R10 no expiry idle", irq_status, 255);

    // R9 reset from a busy state
    start_run(3, 5);
    repeat (30) @(negedge clk);
    rst = 1;
    repeat (2) @(negedge clk); #1;
    chk(line_no == 0 && cyc_now == 0, "R9 reset clears counts", cyc_now, 0);
    chk(irq_status == 8'hFF, "R9 reset status", irq_status, 255);
    rst = 0; adv = 0;
    repeat (3) @(negedge clk); #1;
    chk(irq_status == 8'hFF, "R9 timers disarmed", irq_status, 255);

    finished = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule